// File: doc/BRIEF.md
# Patterned Buzzer Driver

This block drives a piezo buzzer with a square wave. The wave always has 50% duty. It runs at one of three carrier rates: 0.5 kHz, 1 kHz or 2 kHz. A 2-bit mode chooses a slow gating envelope for the carrier. The envelope can be an 8 Hz on/off rate, that 8 Hz rate gated again by a 1 Hz envelope, a single burst timed from a 32 Hz base, or no gating at all.

A one-cycle start pulse loads the frequency select and the mode, then begins playback. The sound keeps going until a stop pulse arrives. The single-burst mode is the exception: it ends by itself. The busy output is active low and marks playback, so a controller can queue the next sound.

Every divide ratio comes from the system clock parameter. A start clears all counters, so the carrier and every envelope begin in their high phase.

Top module: `buzz_pattern_drv`

## Requirements
- R1: The carrier half-period is CLK_HZ/1000 cycles for freq_sel_i=00, CLK_HZ/2000 for 01 and CLK_HZ/4000 for 10. The carrier has 50% duty and is high in the first half-period after a start.
- R2: Mode 11 (continuous) sends the ungated carrier to buzz_o for as long as playback lasts.
- R3: In mode 00, the carrier is ANDed with an 8 Hz envelope of 50% duty, whose half-period is CLK_HZ/16 cycles. The envelope starts in its on phase.
- R4: In mode 01, the carrier is ANDed with both the 8 Hz envelope and a 1 Hz envelope. The 1 Hz envelope has 50% duty, a half-period of CLK_HZ/2 cycles, and starts on.
- R5: In mode 10, the carrier plays ungated for exactly CLK_HZ/64 cycles, which is one 32 Hz half-period. The block then returns to idle and busy_no goes high.
- R6: A stop_i pulse ends playback from the next cycle on. If stop_i and start_i are high in the same cycle, stop_i wins and playback does not start.
- R7: busy_no is low exactly while playback runs. buzz_o is low whenever the block is idle. After reset the block is idle.
- R8: A start_i during playback restarts it at once with the new settings. All counters are cleared.
- R9: freq_sel_i=11 selects the same carrier as 10, with a half-period of CLK_HZ/4000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; loads freq_sel_i and mode_i |
| stop_i | input | 1 | Stop pulse |
| freq_sel_i | input | 2 | Carrier select: 00 0.5 kHz, 01 1 kHz, 10/11 2 kHz |
| mode_i | input | 2 | Gating mode: 00 8 Hz, 01 8 Hz in 1 Hz, 10 single, 11 continuous |
| buzz_o | output | 1 | Gated square-wave output |
| busy_no | output | 1 | Low while playing |

## Verification
A start or stop sampled at one clock edge shows on busy_no and buzz_o right after that edge, because both outputs come straight from registers. The bench model works out the output from the number of cycles since the start edge. It compares the model with the design on every falling edge, half a cycle after the registers change. The single-burst end is due CLK_HZ/64 cycles after the start edge, and the per-cycle comparison catches an end that comes one cycle early or one cycle late. The bench sets CLK_HZ to 16000, so every envelope boundary, including a full 1 Hz period, falls inside the run.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  typedef enum logic [1:0] {
    MODE_INT8   = 2'b00,
    MODE_INT8X1 = 2'b01,
    MODE_SINGLE = 2'b10,
    MODE_CONT   = 2'b11
  } buzz_mode_e;

  localparam int N_ENV   = 3;
  localparam int ENV_8HZ = 0;
  localparam int ENV_1HZ = 1;
  localparam int ENV_32HZ = 2;

  // envelope half-period in cycles
  function automatic int env_half(input int clk_hz, input int idx);
    case (idx)
      ENV_8HZ: return clk_hz / 16;
      ENV_1HZ: return clk_hz / 2;
      default: return clk_hz / 64;
    endcase
  endfunction
endpackage

// File: rtl/buzz_halfdiv.sv
module buzz_halfdiv #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         phase_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == lim_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (clr_i) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (en_i) begin
      if (last_o) begin
        cnt_q   <= '0;
        phase_o <= ~phase_o;
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q < lim_i);

  a_r1_phase_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !en_i |=> $stable(phase_o));
endmodule

// File: rtl/buzz_ctrl.sv
module buzz_ctrl
  import buzz_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [1:0] freq_sel_i,
  input  logic [1:0] mode_i,
  input  logic       burst_end_i,
  output logic       run_o,
  output logic       restart_o,
  output buzz_mode_e mode_o,
  output logic [1:0] fsel_o
);
  assign restart_o = start_i & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      mode_o <= MODE_CONT;
      fsel_o <= 2'b00;
    end else if (stop_i) begin
      run_o <= 1'b0;
    end else if (start_i) begin
      run_o  <= 1'b1;
      mode_o <= buzz_mode_e'(mode_i);
      fsel_o <= freq_sel_i;
    end else if (run_o && mode_o == MODE_SINGLE && burst_end_i) begin
      run_o <= 1'b0;
    end
  end

  a_r5_self_end_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) && !$past(stop_i) |-> $past(mode_o) == MODE_SINGLE);

  a_r6_stop_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_o);
endmodule

// File: rtl/buzz_pattern_drv.sv
module buzz_pattern_drv
  import buzz_pkg::*;
#(
  parameter int CLK_HZ = 4096000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [1:0] freq_sel_i,
  input  logic [1:0] mode_i,
  output logic       buzz_o,
  output logic       busy_no
);
  localparam int HC_05K = CLK_HZ / 1000;
  localparam int HC_1K  = CLK_HZ / 2000;
  localparam int HC_2K  = CLK_HZ / 4000;
  localparam int WC     = $clog2(HC_05K + 1);
  localparam int WE     = $clog2(env_half(CLK_HZ, ENV_1HZ) + 1);

  logic       run, restart;
  buzz_mode_e mode;
  logic [1:0] fsel;
  logic [WC-1:0] car_lim;
  logic       car_ph, car_last;
  logic [N_ENV-1:0] env_ph, env_last;
  logic       gate;

  buzz_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .freq_sel_i  (freq_sel_i),
    .mode_i      (mode_i),
    .burst_end_i (env_last[ENV_32HZ]),
    .run_o       (run),
    .restart_o   (restart),
    .mode_o      (mode),
    .fsel_o      (fsel)
  );

  always_comb begin
    case (fsel)
      2'b00:   car_lim = WC'(HC_05K);
      2'b01:   car_lim = WC'(HC_1K);
      default: car_lim = WC'(HC_2K);
    endcase
  end

  buzz_halfdiv #(.W(WC)) u_carrier (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart),
    .en_i    (run),
    .lim_i   (car_lim),
    .phase_o (car_ph),
    .last_o  (car_last)
  );

  for (genvar g = 0; g < N_ENV; g++) begin : g_env
    buzz_halfdiv #(.W(WE)) u_env (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (restart),
      .en_i    (run),
      .lim_i   (WE'(env_half(CLK_HZ, g))),
      .phase_o (env_ph[g]),
      .last_o  (env_last[g])
    );
  end

  always_comb begin
    case (mode)
      MODE_INT8:   gate = env_ph[ENV_8HZ];
      MODE_INT8X1: gate = env_ph[ENV_8HZ] & env_ph[ENV_1HZ];
      default:     gate = 1'b1;
    endcase
  end

  assign buzz_o  = run & car_ph & gate;
  assign busy_no = ~run;

  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_no |-> !buzz_o);

  a_r8_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i |=> !busy_no);

  a_r6_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> busy_no && !buzz_o);

  a_r2_cont_no_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no && mode == MODE_CONT && $rose(car_ph) && !$past(restart) |-> buzz_o);

  a_r1_carrier_start_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> car_ph);
endmodule

// File: tb/buzz_pattern_drv_test.sv
module buzz_pattern_drv_test;
  localparam int CLK_HZ = 16000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic [1:0] fsel = 2'b00, mode = 2'b00;
  logic buzz, busy_n;

  int checks = 0, errors = 0;
  string tag = "R7";

  // model state
  bit m_run = 0;
  int m_t = 0;
  int m_mode = 0, m_fsel = 0;

  always #4 clk = ~clk;

  buzz_pattern_drv #(.CLK_HZ(CLK_HZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .freq_sel_i(fsel), .mode_i(mode), .buzz_o(buzz), .busy_no(busy_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_t = 0;
    end else if (stop) begin
      m_run = 0;
    end else if (start) begin
      m_run = 1; m_t = 0; m_mode = int'(mode); m_fsel = int'(fsel);
    end else if (m_run) begin
      if (m_mode == 2 && m_t == CLK_HZ/64 - 1) m_run = 0;
      else m_t++;
    end
  end

  function automatic bit exp_buzz();
    int hc;
    bit car, e8, e1, g;
    if (!m_run) return 0;
    hc  = (m_fsel == 0) ? CLK_HZ/1000 : (m_fsel == 1) ? CLK_HZ/2000 : CLK_HZ/4000;
    car = ((m_t / hc) % 2) == 0;
    e8  = ((m_t / (CLK_HZ/16)) % 2) == 0;
    e1  = ((m_t / (CLK_HZ/2)) % 2) == 0;
    g   = (m_mode == 0) ? e8 : (m_mode == 1) ? (e8 & e1) : 1'b1;
    return car & g;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(tag, buzz, exp_buzz(), "buzz_o");
    check(m_run ? tag : "R7", busy_n, !m_run, "busy_no");
  end

  task automatic go(input logic [1:0] f, input logic [1:0] m, input string t);
    @(negedge clk);
    tag = t; fsel = f; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3;
    check("R7", busy_n, 1'b1, "busy_no in reset");
    check("R7", buzz, 1'b0, "buzz_o in reset");
    idle(2);
    rst_n = 1'b1;
    idle(5);
    // R2 continuous, 0.5 kHz
    go(2'b00, 2'b11, "R2"); idle(200); halt();
    tag = "R6"; idle(20);
    // R1 other carriers
    go(2'b01, 2'b11, "R1"); idle(100); halt(); idle(5);
    go(2'b10, 2'b11, "R1"); idle(100); halt(); idle(5);
    // R9 reserved select
    go(2'b11, 2'b11, "R9"); idle(100); halt(); idle(5);
    // R3 8 Hz gating
    go(2'b01, 2'b00, "R3"); idle(2500); halt(); idle(5);
    // R4 8 Hz within 1 Hz, beyond a full 1 Hz period
    go(2'b10, 2'b01, "R4"); idle(17000); halt(); idle(5);
    // R5 single burst ends alone
    go(2'b00, 2'b10, "R5"); idle(400);
    check("R5", busy_n, 1'b1, "busy_no after burst");
    // R6 start and stop together
    @(negedge clk); tag = "R6"; mode = 2'b11; start = 1'b1; stop = 1'b1;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    check("R6", busy_n, 1'b1, "busy_no after start+stop");
    idle(10);
    // R8 restart during playback
    go(2'b00, 2'b00, "R8"); idle(1300);
    go(2'b01, 2'b11, "R8"); idle(60);
    go(2'b10, 2'b10, "R8"); idle(30);
    go(2'b00, 2'b11, "R8"); idle(50); halt();
    tag = "R7"; idle(20);
    check("R7", buzz, 1'b0, "buzz_o idle");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule